// File: doc/BRIEF.md
# Conversion Start and Settling Sequencer

This block is the timing controller for the back end of a delta-sigma converter. It decides when a conversion result may be presented and whether that result fully reflects the current analog input. It raises a one-clock data-ready pulse when each result is available. It also drives a level flag that is high only while the results reflect a settled input. The filter arithmetic, the modulator and the host serial link sit outside this block. The sequencer only counts clock cycles on their behalf.

A conversion is launched by a rising level on a start pin or by a one-cycle start command. On a launch the block samples its configuration: filter type, auto-zero mode, continuous or single-shot mode, conversion period and start delay. It then waits out the start delay. After that it counts as many conversion periods as the chosen filter needs before its first result is valid. Auto-zero mode doubles that count.

In continuous mode, results follow every period after the first. When the input is reported to have changed at an arbitrary moment, the settled flag is withheld for a computed number of results. A filter choice that is not allowed at the chosen rate silences the block and raises an error flag.

Top module: `conv_settle_seq`

## Requirements
- R1: After reset `drdy`, `settled` and `cfg_err` are low, and no `drdy` pulse occurs until a start request.
- R2: A high `start_cmd` sampled on a clock edge is a start request. A low-to-high change of `start_pin`, seen through `SYNC_STAGES` (default 2) synchronizer flops, is also a start request. Holding `start_pin` high does not create further requests.
- R3: With start delay D cycles and period P cycles, the first `drdy` is launched D + L·P cycles after the edge that samples the start request. L depends on `filt_sel`: 1 for code 0 (sinc1), 2 for code 1 (sinc2), 3 for code 2 (sinc3), 4 for code 3 (sinc4), 1 for code 4 (sinc5) and 1 for code 5 (FIR).
- R4: With `az_mode` high at the start request, L is doubled.
- R5: With `cont_mode` high, further `drdy` pulses follow every P cycles after the first. With `cont_mode` low, only the first result is signalled.
- R6: `drdy` is high for exactly one clock when P is 2 or more.
- R7: A start request while a sequence is running aborts it, drops `settled`, and restarts the full first-result latency from the new request.
- R8: Codes 6 and 7 are illegal. Code 4 is also illegal while `fast_rate` is low. A start request with an illegal setting raises `cfg_err` on the next cycle and suppresses every `drdy` until a legal start request clears `cfg_err`.
- R9: `settled` is low after a start request and rises together with the first `drdy` of that sequence.
- R10: A high `in_chg` drops `settled` on the next cycle. `settled` then stays low until L+1 further results have been signalled, and rises together with the (L+1)-th one. Here L is the sampled value including the auto-zero doubling.
- R11: An `in_chg` sampled on the same edge that launches a `drdy` pulse wins. That result is not counted toward the L+1.
- R12: The filter, mode, period and delay inputs are sampled only on a start request. Changing them during a sequence does not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_pin | input | 1 | Start pin, asynchronous, rising level starts |
| start_cmd | input | 1 | Synchronous one-cycle start command |
| filt_sel | input | 3 | Filter type code |
| fast_rate | input | 1 | High when the highest data-rate group is selected |
| cont_mode | input | 1 | 1 = continuous conversions, 0 = single result |
| az_mode | input | 1 | Auto-zero mode, doubles first-result latency |
| period_cyc | input | PER_W | Conversion period in clock cycles |
| delay_cyc | input | DLY_W | Start delay in clock cycles |
| in_chg | input | 1 | Pulse: analog input changed asynchronously to conversions |
| drdy | output | 1 | One-clock data-ready pulse |
| settled | output | 1 | Current results reflect a settled input |
| cfg_err | output | 1 | Last start used an illegal filter/rate setting |

## Verification
Two things can land on one clock edge: an input-change report and the launch of a data-ready pulse. They compete for the settling counter. The bench measures the free-running period and asserts `in_chg` exactly one cycle before a `drdy` becomes visible, so both are sampled on the same edge. It then expects `settled` low with that pulse, and high only with the third later pulse for a two-period filter. If that result had been counted, `settled` would rise one result earlier.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

   localparam int LAT_W = 4;

   typedef enum logic [2:0] {
      FILT_SINC1 = 3'd0,
      FILT_SINC2 = 3'd1,
      FILT_SINC3 = 3'd2,
      FILT_SINC4 = 3'd3,
      FILT_SINC5 = 3'd4,
      FILT_FIR   = 3'd5
   } filt_e;

   typedef enum logic [2:0] {
      SEQ_IDLE  = 3'd0,
      SEQ_DELAY = 3'd1,
      SEQ_FIRST = 3'd2,
      SEQ_RUN   = 3'd3,
      SEQ_ERR   = 3'd4
   } seq_st_e;

   // periods needed before the first valid result (without auto-zero)
   function automatic logic [LAT_W-1:0] base_periods(input logic [2:0] code);
      logic [LAT_W-1:0] r;
      case (code)
         FILT_SINC1: r = LAT_W'(1);
         FILT_SINC2: r = LAT_W'(2);
         FILT_SINC3: r = LAT_W'(3);
         FILT_SINC4: r = LAT_W'(4);
         FILT_SINC5: r = LAT_W'(1);
         FILT_FIR:   r = LAT_W'(1);
         default:    r = '0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cs_start_detect.sv
module cs_start_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_pin,
   input  logic start_cmd,
   output logic start_evt
);

   logic pin_s;
   logic pin_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign pin_s = start_pin;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-1:0] << 1} | {{(SYNC_STAGES-1){1'b0}}, start_pin};
         end
         assign pin_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= pin_s;
   end

   assign start_evt = start_cmd | (pin_s & ~pin_q);

   AST_PIN_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_s && !pin_q && !start_cmd) |=> (!start_evt || start_cmd)) else $error("pin edge repeated"); // R2

endmodule

// File: rtl/cs_cfg_check.sv
module cs_cfg_check
   import conv_seq_pkg::*;
#(
   parameter bit SINC5_FAST_ONLY = 1'b1
) (
   input  logic [2:0]       filt_sel,
   input  logic             fast_rate,
   input  logic             az_mode,
   output logic             legal,
   output logic [LAT_W-1:0] lat_eff
);

   logic [LAT_W-1:0] base;
   logic             code_ok;
   logic             rate_ok;

   assign base    = base_periods(filt_sel);
   assign code_ok = (base != '0);

   generate
      if (SINC5_FAST_ONLY) begin : g_rate_rule
         assign rate_ok = !(filt_sel == FILT_SINC5 && !fast_rate);
      end else begin : g_no_rate_rule
         assign rate_ok = 1'b1;
      end
   endgenerate

   assign legal   = code_ok && rate_ok;
   assign lat_eff = az_mode ? (base << 1) : base;

   always_comb begin
      AST_LAT_RANGE: assert (!legal || (lat_eff >= LAT_W'(1) && lat_eff <= LAT_W'(8))) else $error("latency range"); // R3
   end

endmodule

// File: rtl/cs_seq_timer.sv
module cs_seq_timer
   import conv_seq_pkg::*;
#(
   parameter int PER_W = 16,
   parameter int DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_evt,
   input  logic             cfg_legal,
   input  logic [LAT_W-1:0] lat_in,
   input  logic             cont_in,
   input  logic [PER_W-1:0] period_in,
   input  logic [DLY_W-1:0] delay_in,
   output logic             drdy,
   output logic             res_fire,
   output logic             cfg_err,
   output logic [LAT_W-1:0] lat_q
);

   seq_st_e          st;
   logic [PER_W-1:0] pcnt;
   logic [PER_W-1:0] per_q;
   logic [DLY_W-1:0] dcnt;
   logic [LAT_W-1:0] left;
   logic             cont_q;
   logic             drdy_q;
   logic             per_end;

   assign per_end = (pcnt <= PER_W'(1));

   // result launched on this edge (same edge that sets drdy_q)
   always_comb begin
      res_fire = 1'b0;
      if (!start_evt) begin
         if (st == SEQ_FIRST && per_end && left <= LAT_W'(1)) res_fire = 1'b1;
         if (st == SEQ_RUN && per_end)                        res_fire = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SEQ_IDLE;
         pcnt   <= '0;
         per_q  <= '0;
         dcnt   <= '0;
         left   <= '0;
         lat_q  <= '0;
         cont_q <= 1'b0;
         drdy_q <= 1'b0;
      end else begin
         drdy_q <= res_fire;
         if (start_evt) begin
            per_q  <= period_in;
            cont_q <= cont_in;
            lat_q  <= lat_in;
            left   <= lat_in;
            pcnt   <= period_in;
            dcnt   <= delay_in;
            if (!cfg_legal)               st <= SEQ_ERR;
            else if (delay_in == '0)      st <= SEQ_FIRST;
            else                          st <= SEQ_DELAY;
         end else begin
            case (st)
               SEQ_DELAY: begin
                  if (dcnt <= DLY_W'(1)) begin
                     st   <= SEQ_FIRST;
                     pcnt <= per_q;
                     left <= lat_q;
                  end else begin
                     dcnt <= dcnt - DLY_W'(1);
                  end
               end
               SEQ_FIRST: begin
                  if (per_end) begin
                     pcnt <= per_q;
                     if (left <= LAT_W'(1)) st <= cont_q ? SEQ_RUN : SEQ_IDLE;
                     else                   left <= left - LAT_W'(1);
                  end else begin
                     pcnt <= pcnt - PER_W'(1);
                  end
               end
               SEQ_RUN: begin
                  if (per_end) pcnt <= per_q;
                  else         pcnt <= pcnt - PER_W'(1);
               end
               default: ;
            endcase
         end
      end
   end

   assign drdy    = drdy_q;
   assign cfg_err = (st == SEQ_ERR);

   AST_DRDY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (drdy_q && per_q > PER_W'(1) && !start_evt) |=> !drdy_q) else $error("drdy too wide"); // R6
   AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !drdy_q) else $error("drdy while in error"); // R8
   AST_RESTART_NO_DRDY: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> !drdy_q) else $error("drdy right after start"); // R7
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SEQ_IDLE && !start_evt) |=> !drdy_q) else $error("drdy from idle"); // R5

endmodule

// File: rtl/cs_settle_track.sv
module cs_settle_track
   import conv_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_evt,
   input  logic             res_fire,
   input  logic             in_chg,
   input  logic [LAT_W-1:0] lat_q,
   output logic             settled
);

   localparam int CNT_W = LAT_W + 1;

   logic [CNT_W-1:0] need;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         settled <= 1'b0;
         need    <= '0;
      end else if (start_evt) begin
         settled <= 1'b0;
         need    <= '0;
      end else if (in_chg) begin
         settled <= 1'b0;
         need    <= CNT_W'(lat_q) + CNT_W'(1);
      end else if (res_fire) begin
         if (need <= CNT_W'(1)) begin
            settled <= 1'b1;
            need    <= '0;
         end else begin
            need <= need - CNT_W'(1);
         end
      end
   end

   AST_CHG_DROPS_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
      in_chg |=> !settled) else $error("settled after input change"); // R10
   AST_START_CLEARS_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> !settled) else $error("settled after start"); // R7

endmodule

// File: rtl/conv_settle_seq.sv
module conv_settle_seq
   import conv_seq_pkg::*;
#(
   parameter int PER_W           = 16,
   parameter int DLY_W           = 16,
   parameter int SYNC_STAGES     = 2,
   parameter bit SINC5_FAST_ONLY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_pin,
   input  logic             start_cmd,
   input  logic [2:0]       filt_sel,
   input  logic             fast_rate,
   input  logic             cont_mode,
   input  logic             az_mode,
   input  logic [PER_W-1:0] period_cyc,
   input  logic [DLY_W-1:0] delay_cyc,
   input  logic             in_chg,
   output logic             drdy,
   output logic             settled,
   output logic             cfg_err
);

   generate
      if (PER_W < 2)       begin : g_bad_per  $error("PER_W must be at least 2"); end
      if (DLY_W < 1)       begin : g_bad_dly  $error("DLY_W must be at least 1"); end
      if (SYNC_STAGES < 0) begin : g_bad_sync $error("SYNC_STAGES must not be negative"); end
   endgenerate

   logic             start_evt;
   logic             legal;
   logic [LAT_W-1:0] lat_eff;
   logic [LAT_W-1:0] lat_q;
   logic             res_fire;

   cs_start_detect #(.SYNC_STAGES(SYNC_STAGES)) u_start (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_pin (start_pin),
      .start_cmd (start_cmd),
      .start_evt (start_evt)
   );

   cs_cfg_check #(.SINC5_FAST_ONLY(SINC5_FAST_ONLY)) u_cfg (
      .filt_sel  (filt_sel),
      .fast_rate (fast_rate),
      .az_mode   (az_mode),
      .legal     (legal),
      .lat_eff   (lat_eff)
   );

   cs_seq_timer #(.PER_W(PER_W), .DLY_W(DLY_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_evt (start_evt),
      .cfg_legal (legal),
      .lat_in    (lat_eff),
      .cont_in   (cont_mode),
      .period_in (period_cyc),
      .delay_in  (delay_cyc),
      .drdy      (drdy),
      .res_fire  (res_fire),
      .cfg_err   (cfg_err),
      .lat_q     (lat_q)
   );

   cs_settle_track u_settle (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_evt (start_evt),
      .res_fire  (res_fire),
      .in_chg    (in_chg),
      .lat_q     (lat_q),
      .settled   (settled)
   );

   AST_SETTLE_RISES_WITH_DRDY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(settled) |-> drdy) else $error("settled rose without result"); // R9
   AST_ERR_NO_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !drdy) else $error("result during config error"); // R8

endmodule

// File: tb/conv_settle_seq_tb_top.sv
module conv_settle_seq_tb_top;

   localparam int PER_W = 16;
   localparam int DLY_W = 16;
   localparam int SYNC  = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_pin = 1'b0;
   logic             start_cmd = 1'b0;
   logic [2:0]       filt_sel = 3'd0;
   logic             fast_rate = 1'b1;
   logic             cont_mode = 1'b0;
   logic             az_mode = 1'b0;
   logic [PER_W-1:0] period_cyc = 16'd5;
   logic [DLY_W-1:0] delay_cyc = 16'd7;
   logic             in_chg = 1'b0;
   logic             drdy;
   logic             settled;
   logic             cfg_err;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   conv_settle_seq #(.PER_W(PER_W), .DLY_W(DLY_W), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_pin(start_pin), .start_cmd(start_cmd),
      .filt_sel(filt_sel), .fast_rate(fast_rate), .cont_mode(cont_mode), .az_mode(az_mode),
      .period_cyc(period_cyc), .delay_cyc(delay_cyc), .in_chg(in_chg),
      .drdy(drdy), .settled(settled), .cfg_err(cfg_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int base_lat(input int code);
      case (code)
         0: return 1; 1: return 2; 2: return 3; 3: return 4; 4: return 1; 5: return 1;
         default: return 0;
      endcase
   endfunction

   // called at a negedge; returns edges counted until drdy is visible
   task automatic start_measure(input bit use_pin, output int n);
      n = 0;
      if (use_pin) start_pin = 1'b1; else start_cmd = 1'b1;
      do begin
         @(posedge clk); n++;
         @(negedge clk);
         start_cmd = 1'b0;
      end while (!drdy && n < 3000);
   endtask

   // counts drdy pulses over a window of cycles, from a negedge
   task automatic count_drdy(input int cycles, output int cnt);
      cnt = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (drdy) cnt++;
      end
   endtask

   task automatic t_reset;
      chk("R1 drdy at reset", drdy, 0);
      chk("R1 settled at reset", settled, 0);
      chk("R1 cfg_err at reset", cfg_err, 0);
      begin
         int c;
         count_drdy(40, c);
         chk("R1 no drdy without start", c, 0);
      end
   endtask

   task automatic t_latency;
      int n;
      int c;
      cont_mode  = 1'b0;
      period_cyc = 16'd5;
      delay_cyc  = 16'd7;
      for (int az = 0; az < 2; az++) begin
         for (int f = 0; f < 6; f++) begin
            filt_sel = f[2:0];
            az_mode  = az[0];
            start_measure(1'b0, n);
            if (az == 0) chk($sformatf("R3 first latency code %0d", f), n, 7 + base_lat(f) * 5 + 1);
            else         chk($sformatf("R4 az latency code %0d", f), n, 7 + 2 * base_lat(f) * 5 + 1);
            chk("R9 settled with first result", settled, 1);
            count_drdy(20, c);
            chk("R5 single shot gives one result", c, 0);
         end
      end
      az_mode = 1'b0;
   endtask

   task automatic t_zero_delay;
      int n;
      filt_sel  = 3'd1;
      delay_cyc = 16'd0;
      start_measure(1'b0, n);
      chk("R3 zero start delay", n, 2 * 5 + 1);
      delay_cyc = 16'd7;
   endtask

   task automatic t_pin_start;
      int n;
      int c;
      filt_sel = 3'd2;
      start_measure(1'b1, n);
      chk("R2 pin start latency", n, SYNC + 7 + 3 * 5 + 1);
      count_drdy(60, c);
      chk("R2 held pin no restart", c, 0);
      start_pin = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_continuous;
      int n;
      int gap;
      filt_sel  = 3'd0;
      cont_mode = 1'b1;
      start_measure(1'b0, n);
      chk("R3 cont first latency", n, 7 + 5 + 1);
      for (int k = 0; k < 3; k++) begin
         gap = 0;
         @(negedge clk); gap++;
         chk("R6 drdy one clock", drdy, 0);
         while (!drdy && gap < 100) begin @(negedge clk); gap++; end
         chk("R5 continuous spacing", gap, 5);
      end
   endtask

   task automatic t_restart;
      int n;
      int c;
      filt_sel  = 3'd3;
      cont_mode = 1'b0;
      start_cmd = 1'b1;
      @(negedge clk); start_cmd = 1'b0;
      repeat (15) @(negedge clk);
      start_measure(1'b0, n);
      chk("R7 restart full latency", n, 7 + 4 * 5 + 1);
      count_drdy(10, c);
      chk("R7 no stale result", c, 0);
   endtask

   task automatic t_cfg_sampled;
      int n;
      filt_sel = 3'd0;
      az_mode  = 1'b0;
      start_cmd = 1'b1;
      @(negedge clk);
      start_cmd  = 1'b0;
      filt_sel   = 3'd3;
      az_mode    = 1'b1;
      period_cyc = 16'd9;
      n = 1;
      while (!drdy && n < 3000) begin @(negedge clk); n++; end
      chk("R12 config change ignored", n, 7 + 5 + 1);
      period_cyc = 16'd5;
      az_mode    = 1'b0;
   endtask

   task automatic t_illegal;
      int c;
      int n;
      cont_mode = 1'b1;
      fast_rate = 1'b0;
      filt_sel  = 3'd4;
      start_cmd = 1'b1;
      @(negedge clk); start_cmd = 1'b0;
      chk("R8 sinc5 slow rate error", cfg_err, 1);
      count_drdy(80, c);
      chk("R8 no drdy in error", c, 0);
      filt_sel  = 3'd6;
      fast_rate = 1'b1;
      start_cmd = 1'b1;
      @(negedge clk); start_cmd = 1'b0;
      chk("R8 code 6 error", cfg_err, 1);
      count_drdy(40, c);
      chk("R8 no drdy code 6", c, 0);
      filt_sel  = 3'd4;
      cont_mode = 1'b0;
      start_measure(1'b0, n);
      chk("R8 legal sinc5 fast latency", n, 7 + 5 + 1);
      chk("R8 error cleared", cfg_err, 0);
   endtask

   // wait for a drdy visible at a negedge
   task automatic wait_drdy;
      int g = 0;
      do begin @(negedge clk); g++; end while (!drdy && g < 200);
   endtask

   task automatic t_settle;
      int n;
      filt_sel  = 3'd1;
      cont_mode = 1'b1;
      start_measure(1'b0, n);
      chk("R9 settled at first result", settled, 1);
      repeat (2) @(negedge clk);
      in_chg = 1'b1;
      @(negedge clk); in_chg = 1'b0;
      chk("R10 settled dropped", settled, 0);
      for (int k = 1; k <= 3; k++) begin
         wait_drdy();
         chk($sformatf("R10 settled at result %0d", k), settled, (k == 3) ? 1 : 0);
      end
      // coincident: in_chg on the edge that launches the next drdy
      repeat (4) @(negedge clk);
      in_chg = 1'b1;
      @(negedge clk); in_chg = 1'b0;
      chk("R11 drdy on coincident edge", drdy, 1);
      chk("R11 settled low on coincident result", settled, 0);
      for (int k = 1; k <= 3; k++) begin
         wait_drdy();
         chk($sformatf("R11 settled at later result %0d", k), settled, (k == 3) ? 1 : 0);
      end
      start_cmd = 1'b1;
      @(negedge clk); start_cmd = 1'b0;
      chk("R7 start drops settled", settled, 0);
      cont_mode = 1'b0;
      repeat (40) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latency();
      t_zero_delay();
      t_pin_start();
      t_continuous();
      t_restart();
      t_cfg_sampled();
      t_illegal();
      t_settle();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule